// File: doc/BRIEF.md
# Synchronous Serial Receive Master

This block is a three-wire synchronous serial master that only receives. It drives a serial clock derived from the system clock and captures one data input bit per serial clock period. It assembles words of 8 to 16 bits, arriving either MSB-first or LSB-first. Software uses a small register port to set the word length, bit order, clock rate and mode. Software starts a transfer by reading the data register while the block is idle and enabled. It collects each word from the same register after a one-cycle completion interrupt pulse.

There are two modes. In single-shot mode one word is received per start. In continuous mode a continuation bit is examined as each word completes: while it is set, the next word begins at once. Clearing it lets the word in flight finish and then stops the clock. An overrun flag records that a word completed while the previous one was still unread. Received data leaves through a register port, not a stream, so there is no back-pressure. Software must read each word before the next one completes, or the overrun flag records the loss.

Top module: `srx_master`

## Requirements
- R1: After reset, the control word, data register and status register read 0, the serial clock output is high and the interrupt output is low.
- R2: A read strobe at address 1 (data) while control bit 0 (power) and bit 1 (receive enable) are both 1 and the block is idle starts a reception, and status bit 0 (busy) is 1 from the next cycle. A read at any other time returns the last word and starts nothing: the serial clock stays high and busy stays 0.
- R3: The serial clock idles high. Control field [9:8] = s sets a clock period of 2^(s+1) system cycles. The first falling edge comes 2^s cycles after the starting read edge, and a word of L bits completes 2·L·2^s cycles after that edge.
- R4: Control field [7:4] = c gives a word length of c+8 bits for c from 0 to 8. Any larger code gives 16 bits.
- R5: With control bit 2 = 0 the first received bit is the word's MSB. With bit 2 = 1 it is the LSB. The data register is right-aligned and zero-extended.
- R6: Each bit is the data input level sampled at a rising edge of the serial clock, so a sender that changes data on falling edges is received intact.
- R7: Each completed word raises the interrupt output for exactly one cycle, and the data register holds the new word in that same cycle.
- R8: With control bit 3 (continue) = 1 at completion, the next word starts without any read, so completions in the stream are 2·L·2^s cycles apart.
- R9: If the continue bit is cleared while a word is in flight, that word still completes and raises the interrupt. After it, busy is 0, the serial clock stays high and no further word arrives.
- R10: Status bit 1 (overrun) sets when a word completes while the previous word has not been read. It stays 0 if every word is read in time. A write to address 2 with bit 1 = 0 clears it.
- R11: Writing control bit 0 = 0 aborts at once: from the second cycle after the write, busy is 0 and the serial clock is high, and the aborted word raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address: 0 control, 1 data, 2 status |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (matters for the data register only) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| sck_o | output | 1 | Serial clock, idles high |
| sdi_i | input | 1 | Serial data input |
| rx_irq_o | output | 1 | One-cycle receive-complete pulse |

## Verification
Counted from the clock edge that accepts the starting read, busy is visible one cycle later and the interrupt is due exactly 2·L·2^s cycles later. The new word can be read combinationally in that same cycle, while the overrun and unread bookkeeping update one cycle after the interrupt. The bench samples on falling system-clock edges and counts falling edges from the start, so each check lands on the cycle where the result is due rather than "some time later". It also times consecutive completions in continuous mode by a free-running cycle counter. An abort is checked two edges after the control write, and then over a window long enough to cover the rest of the aborted word.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_DATA  = 2'd1,
    A_STAT  = 2'd2,
    A_SPARE = 2'd3
  } srx_addr_e;

  // control word field positions
  localparam int F_PWR  = 0;
  localparam int F_RXEN = 1;
  localparam int F_LSB  = 2;
  localparam int F_CONT = 3;
  localparam int F_LEN  = 4;
  localparam int F_SEL  = 8;

  // status word field positions
  localparam int S_BUSY = 0;
  localparam int S_OVR  = 1;

endpackage

// File: rtl/srx_clkdiv.sv
module srx_clkdiv #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'((1 << sel) - 1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + CNT_W'(1);
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0) |=> (!tick || sel == '0));

endmodule

// File: rtl/srx_engine.sv
module srx_engine #(
  parameter int MAX_W  = 16,
  parameter int MIN_W  = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr,
  input  logic              start,
  input  logic              cont,
  input  logic              lsb,
  input  logic [CODE_W-1:0] len_code,
  input  logic              tick,
  input  logic              sdi,
  output logic              busy,
  output logic              sck,
  output logic              done,
  output logic [MAX_W-1:0]  word
);
  localparam int BC_W     = $clog2(MAX_W + 1);
  localparam int MAX_CODE = MAX_W - MIN_W;

  logic [BC_W-1:0]  eff_len;
  logic [BC_W-1:0]  bitcnt;
  logic [BC_W-1:0]  pos;
  logic             last_bit;
  logic [MAX_W-1:0] shreg;
  logic [MAX_W-1:0] captured;

  always_comb begin
    if (len_code > CODE_W'(MAX_CODE)) eff_len = BC_W'(MAX_W);
    else                              eff_len = BC_W'(MIN_W) + BC_W'(len_code);
  end

  assign pos      = lsb ? bitcnt : (eff_len - bitcnt - BC_W'(1));
  assign last_bit = (bitcnt == eff_len - BC_W'(1));
  assign captured = shreg | (MAX_W'(sdi) << pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sck    <= 1'b1;
      bitcnt <= '0;
      shreg  <= '0;
      word   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!pwr) begin
        busy   <= 1'b0;
        sck    <= 1'b1;
        bitcnt <= '0;
        shreg  <= '0;
      end else if (start && !busy) begin
        busy   <= 1'b1;
        sck    <= 1'b1;
        bitcnt <= '0;
        shreg  <= '0;
      end else if (busy && tick) begin
        if (sck) begin
          sck <= 1'b0;
        end else begin
          sck <= 1'b1;
          if (last_bit) begin
            word   <= captured;
            done   <= 1'b1;
            shreg  <= '0;
            bitcnt <= '0;
            busy   <= cont;
          end else begin
            shreg  <= captured;
            bitcnt <= bitcnt + BC_W'(1);
          end
        end
      end
    end
  end

  // R3
  sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck);

  // R3
  sck_fall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> busy);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/srx_regs.sv
module srx_regs
  import srx_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int CODE_W = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [BUS_W-1:0]  word,
  output logic              pwr,
  output logic              lsb,
  output logic              cont,
  output logic [CODE_W-1:0] len_code,
  output logic [SEL_W-1:0]  sel,
  output logic              start
);
  localparam int CTRL_W = F_SEL + SEL_W;

  srx_addr_e         a;
  logic [CTRL_W-1:0] ctrl;
  logic              rx_en;
  logic              ovr;
  logic              unread;
  logic              rd_data;
  logic              unused_wdata;

  assign a            = srx_addr_e'(addr);
  assign pwr          = ctrl[F_PWR];
  assign rx_en        = ctrl[F_RXEN];
  assign lsb          = ctrl[F_LSB];
  assign cont         = ctrl[F_CONT];
  assign len_code     = ctrl[F_LEN +: CODE_W];
  assign sel          = ctrl[F_SEL +: SEL_W];
  assign rd_data      = rd && (a == A_DATA);
  assign start        = rd_data && pwr && rx_en && !busy;
  assign unused_wdata = ^wdata[BUS_W-1:CTRL_W];

  always_comb begin
    rdata = '0;
    case (a)
      A_CTRL:  rdata[CTRL_W-1:0] = ctrl;
      A_DATA:  rdata = word;
      A_STAT:  begin
        rdata[S_BUSY] = busy;
        rdata[S_OVR]  = ovr;
      end
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      ovr    <= 1'b0;
      unread <= 1'b0;
    end else begin
      if (wr && a == A_CTRL) ctrl <= wdata[CTRL_W-1:0];
      if (wr && a == A_STAT && !wdata[S_OVR]) ovr <= 1'b0;
      if (done) begin
        if (unread) ovr <= 1'b1;
        unread <= !rd_data;
      end else if (rd_data) begin
        unread <= 1'b0;
      end
    end
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R10
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(done && unread));

  // R11
  pwr_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr |=> !busy);

endmodule

// File: rtl/srx_master.sv
module srx_master #(
  parameter int MAX_W  = 16,
  parameter int MIN_W  = 8,
  parameter int CODE_W = 4,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [MAX_W-1:0] reg_wdata,
  output logic [MAX_W-1:0] reg_rdata,
  output logic             sck_o,
  input  logic             sdi_i,
  output logic             rx_irq_o
);
  localparam int BUS_W = MAX_W;

  logic              pwr, lsb, cont, start, busy, tick, done;
  logic [CODE_W-1:0] len_code;
  logic [SEL_W-1:0]  sel;
  logic [MAX_W-1:0]  word;

  srx_regs #(.BUS_W(BUS_W), .CODE_W(CODE_W), .SEL_W(SEL_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .done(done),
    .word(word), .pwr(pwr), .lsb(lsb), .cont(cont), .len_code(len_code),
    .sel(sel), .start(start)
  );

  srx_clkdiv #(.SEL_W(SEL_W)) div_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .sel(sel), .tick(tick)
  );

  srx_engine #(.MAX_W(MAX_W), .MIN_W(MIN_W), .CODE_W(CODE_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .pwr(pwr), .start(start), .cont(cont),
    .lsb(lsb), .len_code(len_code), .tick(tick), .sdi(sdi_i),
    .busy(busy), .sck(sck_o), .done(done), .word(word)
  );

  assign rx_irq_o = done;

endmodule

// File: tb/srx_master_tb.sv
module srx_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] AD_CTRL = 2'd0;
  localparam logic [1:0] AD_DATA = 2'd1;
  localparam logic [1:0] AD_STAT = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sck_o;
  logic        sdi_i = 1'b0;
  logic        rx_irq_o;

  int total = 0;
  int bad = 0;
  int g = 0;
  int slen = 8;
  bit slsb = 1'b0;
  int pbase = 0;
  int cyc = 0;
  int irq_at = 0;

  srx_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_o(sck_o), .sdi_i(sdi_i), .rx_irq_o(rx_irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] pattern(int n);
    return 16'((n * 40503) + 23117 + (n >> 3));
  endfunction

  function automatic logic [15:0] exp_word(int n, int len);
    return pattern(n + pbase) & 16'((32'd1 << len) - 1);
  endfunction

  function automatic logic [15:0] mkcfg(bit pw, bit rx, bit lb, bit ct, int code, int s);
    return 16'(int'(pw) | (int'(rx) << 1) | (int'(lb) << 2) | (int'(ct) << 3) | (code << 4) | (s << 8));
  endfunction

  // sender model: changes data on each falling serial clock edge
  always @(negedge sck_o) begin : sender
    int n, k;
    logic [15:0] w;
    n = g / slen;
    k = g % slen;
    w = pattern(n + pbase);
    sdi_i = slsb ? w[k] : w[slen-1-k];
    g = g + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(output int c);
    c = 0;
    while (rx_irq_o !== 1'b1 && c < 6000) begin
      @(negedge clk);
      c++;
    end
    if (c >= 6000) chk("irq timeout", 0, 1);
    irq_at = cyc;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] d, last_exp;
    int c, prev_at, irqs;
    last_exp = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek(AD_CTRL, d); chk("R1 ctrl", int'(d), 0);
    peek(AD_DATA, d); chk("R1 data", int'(d), 0);
    peek(AD_STAT, d); chk("R1 stat", int'(d), 0);
    chk("R1 sck", int'(sck_o), 1);
    chk("R1 irq", int'(rx_irq_o), 0);

    // sweep: clock select x length code x bit order, single-shot
    for (int s = 0; s < 4; s++) begin
      for (int code = 0; code < 16; code++) begin
        for (int lb = 0; lb < 2; lb++) begin
          int len, h;
          len = (code > 8) ? 16 : code + 8;
          h = 1 << s;
          g = 0; slen = len; slsb = bit'(lb); pbase = s * 97 + code * 5 + lb;
          bus_write(AD_CTRL, mkcfg(1, 1, bit'(lb), 0, code, s));
          bus_read(AD_DATA, d);
          wait_irq(c);
          chk("R3 word time", c, 2 * len * h);
          peek(AD_DATA, d);
          // R4 R5 R6 R7 data in irq cycle
          chk("R5 word", int'(d), int'(exp_word(0, len)));
          last_exp = exp_word(0, len);
          @(negedge clk);
          chk("R7 pulse", int'(rx_irq_o), 0);
          peek(AD_STAT, d); chk("R9 single busy", int'(d[0]), 0);
          bus_read(AD_DATA, d);
          bus_write(AD_CTRL, mkcfg(0, 1, bit'(lb), 0, code, s));
          @(negedge clk);
          peek(AD_STAT, d); chk("R11 busy", int'(d[0]), 0);
          chk("R11 sck", int'(sck_o), 1);
        end
      end
    end

    // R2: read with receive disabled starts nothing, returns last word
    bus_write(AD_CTRL, mkcfg(1, 0, 0, 0, 0, 0));
    g = 0;
    bus_read(AD_DATA, d);
    chk("R2 last word", int'(d), int'(last_exp));
    repeat (10) @(negedge clk);
    chk("R2 no clock", g, 0);
    peek(AD_STAT, d); chk("R2 busy", int'(d[0]), 0);

    // R8 R9 continuous stream, stop after word 4
    g = 0; slen = 8; slsb = 1'b0; pbase = 500;
    bus_write(AD_CTRL, mkcfg(1, 1, 0, 1, 0, 0));
    bus_read(AD_DATA, d);
    prev_at = 0;
    for (int n = 0; n < 5; n++) begin
      wait_irq(c);
      peek(AD_DATA, d);
      chk("R8 stream word", int'(d), int'(exp_word(n, 8)));
      if (n > 0) chk("R8 spacing", irq_at - prev_at, 16);
      prev_at = irq_at;
      if (n < 4) bus_read(AD_DATA, d);
      if (n == 3) bus_write(AD_CTRL, mkcfg(1, 1, 0, 0, 0, 0));
    end
    irqs = 0;
    repeat (40) begin
      @(negedge clk);
      if (rx_irq_o) irqs++;
    end
    chk("R9 no more words", irqs, 0);
    peek(AD_STAT, d);
    chk("R9 busy", int'(d[0]), 0);
    chk("R10 no overrun", int'(d[1]), 0);
    chk("R9 sck", int'(sck_o), 1);
    bus_read(AD_DATA, d);
    bus_write(AD_CTRL, mkcfg(0, 1, 0, 0, 0, 0));

    // R10 overrun
    g = 0; pbase = 900;
    bus_write(AD_CTRL, mkcfg(1, 1, 0, 1, 0, 0));
    bus_read(AD_DATA, d);
    wait_irq(c);
    @(negedge clk);
    peek(AD_STAT, d); chk("R10 first clean", int'(d[1]), 0);
    wait_irq(c);
    @(negedge clk);
    peek(AD_STAT, d); chk("R10 overrun set", int'(d[1]), 1);
    bus_write(AD_STAT, 16'h0000);
    peek(AD_STAT, d); chk("R10 overrun clear", int'(d[1]), 0);
    bus_write(AD_CTRL, mkcfg(0, 1, 0, 1, 0, 0));

    // R11 abort mid-word
    g = 0; slen = 16; pbase = 1300;
    bus_write(AD_CTRL, mkcfg(1, 1, 0, 0, 8, 2));
    bus_read(AD_DATA, d);
    repeat (30) @(negedge clk);
    bus_write(AD_CTRL, mkcfg(0, 1, 0, 0, 8, 2));
    @(negedge clk);
    peek(AD_STAT, d); chk("R11 abort busy", int'(d[0]), 0);
    chk("R11 abort sck", int'(sck_o), 1);
    irqs = 0;
    repeat (200) begin
      @(negedge clk);
      if (rx_irq_o) irqs++;
    end
    chk("R11 no irq", irqs, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule